// File: doc/BRIEF.md
# Transmit Byte Queue with Byte and Word Push

This block holds outgoing serial data between a register bus and a serial shifter. The bus side can write into it in two ways. One strobe loads a single byte taken from the low eight bits of the write data. A second strobe loads a full 32-bit word as four bytes. Both paths feed one queue that is organised by byte. The shifter side takes one byte at a time through a valid/ready handshake.

Software normally writes whole words while four or more bytes of a payload are left, and sends the trailing one to three bytes through the byte strobe. The block reports its free space in bytes in the upper half of a status word. It also drives empty, full and overrun indications toward an interrupt controller. A push that does not fit is discarded as a whole, so a word is never split.

The depth `DEPTH` must be a power of two and at least four. Its default is 64 bytes.

Top module: `tx_byte_queue`

## Requirements
- R1: After reset, the queue is empty: flag_empty=1, flag_full=0, flag_overrun=0, pop_valid=0, and the free field reads DEPTH.
- R2: A byte push (byte_push=1, word_push=0) with room enqueues push_data[7:0] as one byte and ignores push_data[31:8].
- R3: A word push with at least four free bytes enqueues four bytes, least significant first: push_data[7:0], then [15:8], then [23:16], then [31:24].
- R4: Bytes leave in the order they were enqueued. pop_valid is 1 exactly when the queue is not empty, and pop_data shows the oldest byte. A byte is removed on a clock edge where pop_valid and pop_ready are both 1.
- R5: status_word[31:16] holds DEPTH minus the number of stored bytes, and status_word[15:0] reads zero. The field shows the effect of a push or pop from the cycle after the clock edge on which it happened.
- R6: A byte push while the queue is full stores nothing. flag_overrun is 1 for exactly the one cycle after that edge.
- R7: A word push with fewer than four free bytes stores none of its four bytes and raises flag_overrun for one cycle, as in R6.
- R8: flag_empty is 1 when no bytes are stored. flag_full is 1 when DEPTH bytes are stored.
- R9: A push and a pop on the same edge both take effect. Whether the push fits is judged on the occupancy before that edge's pop.
- R10: If byte_push and word_push are both 1 on the same edge, only the word push is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_push | input | 1 | Enqueue push_data[7:0] as one byte |
| word_push | input | 1 | Enqueue all four bytes of push_data |
| push_data | input | 32 | Write data shared by both push strobes |
| pop_ready | input | 1 | Shifter accepts the head byte |
| pop_valid | output | 1 | A byte is available at pop_data |
| pop_data | output | 8 | Oldest stored byte |
| status_word | output | 32 | Free byte count in bits 31:16, zeros below |
| flag_empty | output | 1 | No bytes stored |
| flag_full | output | 1 | DEPTH bytes stored |
| flag_overrun | output | 1 | One-cycle pulse after a rejected push |

## Verification
The bench uses the default DEPTH of 64 with four byte lanes, so 16 word pushes fill the queue in a few cycles. At that size the full state, the case of exactly two free bytes where a word must be refused, and pointer wrap-around across the byte array all come up in a short run. A pop and a refused push on the same edge, and both strobes raised together, are each driven on purpose at these sizes.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Bytes still free when occ bytes are held in a queue of the given depth.
  function automatic int unsigned free_of(input int unsigned occ, input int unsigned depth);
    return depth - occ;
  endfunction

  // A push of n bytes fits when free space is at least n.
  function automatic logic fits(input int unsigned occ, input int unsigned depth,
                                input int unsigned n);
    return (depth - occ) >= n;
  endfunction

endpackage

// File: rtl/txq_admit.sv
module txq_admit #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(LANES + 1)
) (
  input  logic          byte_push,
  input  logic          word_push,
  input  logic [CW-1:0] occ,
  output logic [TW-1:0] take_n,
  output logic          reject
);
  import txq_pkg::*;

  always_comb begin
    take_n = '0;
    reject = 1'b0;
    if (word_push) begin
      if (fits(int'(occ), DEPTH, LANES)) take_n = TW'(LANES);
      else reject = 1'b1;
    end else if (byte_push) begin
      if (fits(int'(occ), DEPTH, 1)) take_n = TW'(1);
      else reject = 1'b1;
    end
  end

endmodule

// File: rtl/txq_level.sv
module txq_level #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] take_n,
  input  logic          pop_fire,
  output logic [CW-1:0] occ,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ    <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      occ    <= occ + CW'(take_n) - CW'(pop_fire);
      wr_ptr <= wr_ptr + AW'(take_n);
      rd_ptr <= rd_ptr + AW'(pop_fire);
    end
  end

endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int TW = $clog2(LANES + 1),
  localparam int WW = 8 * LANES
) (
  input  logic          clk,
  input  logic [TW-1:0] take_n,
  input  logic [AW-1:0] wr_ptr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] rd_ptr,
  output logic [7:0]    rd_byte
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] lane_addr [LANES];

  // Lane k lands k bytes after the write pointer; wrap comes from the AW-bit width.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_addr[k] = wr_ptr + AW'(k);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(take_n)) mem[lane_addr[k]] <= wdata[8*k +: 8];
    end
  end

  assign rd_byte = mem[rd_ptr];

endmodule

// File: rtl/tx_byte_queue.sv
module tx_byte_queue #(
  parameter int DEPTH = 64,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(LANES + 1),
  localparam int WW = 8 * LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_push,
  input  logic          word_push,
  input  logic [WW-1:0] push_data,
  input  logic          pop_ready,
  output logic          pop_valid,
  output logic [7:0]    pop_data,
  output logic [31:0]   status_word,
  output logic          flag_empty,
  output logic          flag_full,
  output logic          flag_overrun
);
  import txq_pkg::*;

  logic [CW-1:0] occ;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [TW-1:0] push_take_n;
  logic          push_reject;
  logic          pop_fire;
  logic          ovr_q;

  txq_admit #(.DEPTH(DEPTH), .LANES(LANES)) u_admit (
    .byte_push (byte_push),
    .word_push (word_push),
    .occ       (occ),
    .take_n    (push_take_n),
    .reject    (push_reject)
  );

  txq_level #(.DEPTH(DEPTH), .LANES(LANES)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_n   (push_take_n),
    .pop_fire (pop_fire),
    .occ      (occ),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr)
  );

  txq_store #(.DEPTH(DEPTH), .LANES(LANES)) u_store (
    .clk     (clk),
    .take_n  (push_take_n),
    .wr_ptr  (wr_ptr),
    .wdata   (push_data),
    .rd_ptr  (rd_ptr),
    .rd_byte (pop_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= push_reject;
  end

  assign pop_valid    = (occ != '0);
  assign pop_fire     = pop_valid & pop_ready;
  assign flag_empty   = (occ == '0);
  assign flag_full    = (occ == CW'(DEPTH));
  assign flag_overrun = ovr_q;
  assign status_word  = {16'(free_of(int'(occ), DEPTH)), 16'h0000};

endmodule

// File: rtl/tx_byte_queue_chk.sv
module tx_byte_queue_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_push,
  input logic        word_push,
  input logic        pop_valid,
  input logic        pop_fire,
  input logic [31:0] status_word,
  input logic        flag_empty,
  input logic        flag_full,
  input logic        flag_overrun
);

  logic [15:0] free;
  assign free = status_word[31:16];

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free) <= DEPTH); // R5

  AST_BYTE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_push && !word_push && !flag_full && !pop_fire |=> int'(free) == int'($past(free)) - 1); // R2

  AST_WORD_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    word_push && free >= 16'd4 && !pop_fire |=> int'(free) == int'($past(free)) - 4); // R3

  AST_EMPTY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    flag_empty |-> !pop_valid); // R4

  AST_BYTE_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    byte_push && !word_push && flag_full |=> flag_overrun); // R6

  AST_WORD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    word_push && free < 16'd4 |=> flag_overrun && int'(free) == int'($past(free)) + int'($past(pop_fire))); // R7

  AST_FULL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_full |-> free == 16'd0); // R8

  AST_POP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire && !byte_push && !word_push |=> int'(free) == int'($past(free)) + 1); // R9

  AST_BOTH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    word_push && byte_push && free >= 16'd4 && !pop_fire |=> int'(free) == int'($past(free)) - 4); // R10

endmodule

bind tx_byte_queue tx_byte_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .byte_push    (byte_push),
  .word_push    (word_push),
  .pop_valid    (pop_valid),
  .pop_fire     (pop_fire),
  .status_word  (status_word),
  .flag_empty   (flag_empty),
  .flag_full    (flag_full),
  .flag_overrun (flag_overrun)
);

// File: tb/tb_tx_byte_queue.sv
module tb_tx_byte_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_push = 1'b0;
  logic        word_push = 1'b0;
  logic [31:0] push_data = '0;
  logic        pop_ready = 1'b0;
  logic        pop_valid;
  logic [7:0]  pop_data;
  logic [31:0] status_word;
  logic        flag_empty;
  logic        flag_full;
  logic        flag_overrun;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  logic exp_ovr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_byte_queue #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .byte_push(byte_push), .word_push(word_push),
    .push_data(push_data), .pop_ready(pop_ready), .pop_valid(pop_valid),
    .pop_data(pop_data), .status_word(status_word), .flag_empty(flag_empty),
    .flag_full(flag_full), .flag_overrun(flag_overrun)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: check state left by the last edge, then drive the next edge.
  task automatic tick(input logic bp, input logic wp, input logic [31:0] d,
                      input logic rdy, input string tag);
    int occ;
    @(negedge clk); #1;
    occ = exp_q.size();
    check(tag, "free R5", int'(status_word[31:16]), DEPTH - occ);
    check("R5", "status low half", int'(status_word[15:0]), 0);
    check(tag, "empty R8", int'(flag_empty), int'(occ == 0));
    check(tag, "full R8", int'(flag_full), int'(occ == DEPTH));
    check(tag, "valid R4", int'(pop_valid), int'(occ != 0));
    check(tag, "overrun", int'(flag_overrun), int'(exp_ovr));
    exp_ovr = 1'b0;
    if (wp) begin
      if (DEPTH - occ >= 4) for (int k = 0; k < 4; k++) exp_q.push_back(d[8*k +: 8]);
      else exp_ovr = 1'b1;
    end else if (bp) begin
      if (occ < DEPTH) exp_q.push_back(d[7:0]);
      else exp_ovr = 1'b1;
    end
    byte_push = bp;
    word_push = wp;
    push_data = d;
    pop_ready = rdy;
  endtask

  // Scoreboard monitor: compares each byte that leaves against the model queue.
  initial begin
    forever begin
      @(negedge clk); #3;
      if (rst_n && pop_valid && pop_ready) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R4 pop with empty model actual=%0d expected=none", pop_data);
        end else begin
          check("R4", "pop order", int'(pop_data), int'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    tick(0, 0, 0, 0, "R1");
    // R2: upper bits of the write data are ignored by a byte push
    tick(1, 0, 32'hABCDEF11, 0, "R2");
    tick(1, 0, 32'h00000022, 0, "R2");
    // R3: a word goes in low byte first
    tick(0, 1, 32'h66554433, 0, "R3");
    tick(0, 0, 0, 0, "R3");
    repeat (8) tick(0, 0, 0, 1, "R4");
    // Fill to full with words (pointer wraps around the array)
    for (int i = 0; i < 16; i++) tick(0, 1, 32'h01020304 * (i + 1) ^ 32'h5A5A5A5A, 0, "R8");
    tick(0, 0, 0, 0, "R8");
    // R6: byte push while full
    tick(1, 0, 32'h00000099, 0, "R6");
    tick(0, 0, 0, 0, "R6");
    tick(0, 0, 0, 0, "R6");
    // R7: two bytes free, a word does not fit
    tick(0, 0, 0, 1, "R7");
    tick(0, 0, 0, 1, "R7");
    tick(0, 1, 32'hDEADBEEF, 0, "R7");
    tick(0, 0, 0, 0, "R7");
    tick(1, 0, 32'h000000C1, 0, "R7");
    tick(1, 0, 32'h000000C2, 0, "R7");
    tick(0, 0, 0, 0, "R8");
    // R9: pop and push on the same edge, fit judged before the pop
    tick(1, 0, 32'h00000077, 1, "R9");
    tick(1, 0, 32'h00000078, 1, "R9");
    tick(0, 0, 0, 0, "R9");
    repeat (70) tick(0, 0, 0, 1, "R4");
    // R10: both strobes together act as a word push
    tick(1, 1, 32'hD4C3B2A1, 0, "R10");
    tick(0, 0, 0, 0, "R10");
    repeat (6) tick(0, 0, 0, 1, "R10");
    tick(0, 0, 0, 0, "R8");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule